// File: doc/BRIEF.md
# Rectangle fill and copy engine

A two-dimensional drawing coprocessor for a linearly addressed frame buffer with one byte per pixel. Software programs a small register set (source and destination base addresses, an independent scanline pitch for each side, the rectangle's width and height, a direction flag, a fill colour, a start coordinate and an optional inclusive clip window), then writes an instruction code that starts either a solid fill or a rectangle copy.

The engine walks the rectangle line by line. Each pixel becomes one write (fill) or one read followed by one write (copy) on a simple request/ready memory port. In reverse mode the base addresses name the last pixel of the rectangle and every step moves toward lower addresses and coordinates, so an overlapping copy toward higher addresses never reads a pixel it has already overwritten. Pixels outside the enabled clip window make no memory access. A four-bit status field reads zero only while the engine is idle.

Top module: `rect_blit_engine`

## Requirements
- R1: Register indices on `reg_addr_i`: 0 source base, 1 destination base, 2 source pitch, 3 destination pitch, 4 width, 5 height, 6 mode (bit 0 reverse, bit 1 clip enable), 7 fill colour, 8 clip left, 9 clip right, 10 clip top, 11 clip bottom, 12 start X, 13 start Y, 15 command; pitches, sizes, coordinates and clip bounds are DIM_W bits wide, addresses ADDR_W bits.
- R2: Writing 1 to the command low byte while idle starts a fill and writing 2 starts a copy; any other code, or a width or height of zero, leaves the engine idle with no memory request.
- R3: A fill writes the fill colour exactly once to each destination pixel in row-major order, at address base + row × destination pitch + column.
- R4: A copy reads each source pixel (base + row × source pitch + column) and then writes the value read to the matching destination pixel before moving to the next pixel.
- R5: With reverse set, addresses and the X coordinate decrease by one per pixel and the line base decreases by the pitch and Y by one per line, starting from the programmed base addresses and start coordinate.
- R6: With clip enabled, a pixel is accessed only if left ≤ X ≤ right and top ≤ Y ≤ bottom, where X and Y are the destination coordinates that start at the programmed start coordinate; a clipped pixel makes no read or write.
- R7: A memory request holds its address, direction and write data until `mem_ready_i` is high; read data is taken in the cycle the read is accepted.
- R8: `status_o` is 0 while idle; while busy bit 0 is 1, bit 1 marks a copy, bit 2 marks a fill and bit 3 is 0.
- R9: While busy every register write, the command included, is ignored.
- R10: When the last pixel is visible, `status_o` reads 0 in the cycle after its write is accepted.
- R11: Addresses wrap modulo 2^ADDR_W.
- R12: After reset the engine is idle with `status_o` 0, no memory request and all registers 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register index |
| reg_wdata_i | input | DATA_W | Register write data |
| status_o | output | 4 | Busy status, zero when idle |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 write, 0 read |
| mem_addr_o | output | ADDR_W | Pixel address |
| mem_wdata_o | output | PIX_W | Write data |
| mem_rdata_i | input | PIX_W | Read data, valid with ready on a read |
| mem_ready_i | input | 1 | Memory accepts the current request |

## Verification
The bench builds the engine with ADDR_W = 12, DIM_W = 16 and DATA_W = 16, so the whole 4 KiB frame buffer fits in a bench array that can be compared byte for byte after every operation. The short address space puts wrap-around past the top address within reach of a four-pixel fill, while 16-bit coordinates keep the clip comparisons at full width. An overlapping reverse copy, clip windows that cut the first and last pixels, and a stalling memory are run against a behavioural model that predicts every request in order.

// File: rtl/blit_pkg.sv
package blit_pkg;
  typedef enum logic [3:0] {
    REG_SRC    = 4'd0,
    REG_DST    = 4'd1,
    REG_SPITCH = 4'd2,
    REG_DPITCH = 4'd3,
    REG_WIDTH  = 4'd4,
    REG_HEIGHT = 4'd5,
    REG_MODE   = 4'd6,
    REG_COLOR  = 4'd7,
    REG_CLIP_L = 4'd8,
    REG_CLIP_R = 4'd9,
    REG_CLIP_T = 4'd10,
    REG_CLIP_B = 4'd11,
    REG_X0     = 4'd12,
    REG_Y0     = 4'd13,
    REG_CMD    = 4'd15
  } reg_idx_e;

  localparam logic [7:0] CMD_FILL = 8'd1;
  localparam logic [7:0] CMD_COPY = 8'd2;

  localparam int MODE_REV_BIT  = 0;
  localparam int MODE_CLIP_BIT = 1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } state_e;
endpackage

// File: rtl/blit_regs.sv
module blit_regs
  import blit_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DIM_W  = 16,
  parameter int PIX_W  = 8,
  parameter int DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [3:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              busy_i,
  output logic [ADDR_W-1:0] src_base_o,
  output logic [ADDR_W-1:0] dst_base_o,
  output logic [DIM_W-1:0]  src_pitch_o,
  output logic [DIM_W-1:0]  dst_pitch_o,
  output logic [DIM_W-1:0]  width_o,
  output logic [DIM_W-1:0]  height_o,
  output logic              reverse_o,
  output logic              clip_en_o,
  output logic [PIX_W-1:0]  color_o,
  output logic [DIM_W-1:0]  clip_l_o,
  output logic [DIM_W-1:0]  clip_r_o,
  output logic [DIM_W-1:0]  clip_t_o,
  output logic [DIM_W-1:0]  clip_b_o,
  output logic [DIM_W-1:0]  x0_o,
  output logic [DIM_W-1:0]  y0_o,
  output logic              start_o,
  output logic              copy_o
);
  logic       wr_en;
  logic [7:0] cmd;
  logic       unused_wdata;

  assign wr_en        = we_i && !busy_i;
  assign cmd          = wdata_i[7:0];
  assign unused_wdata = ^wdata_i;

  assign copy_o  = (cmd == CMD_COPY);
  assign start_o = wr_en && (addr_i == REG_CMD) && ((cmd == CMD_FILL) || (cmd == CMD_COPY))
                   && (width_o != '0) && (height_o != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_base_o  <= '0;
      dst_base_o  <= '0;
      src_pitch_o <= '0;
      dst_pitch_o <= '0;
      width_o     <= '0;
      height_o    <= '0;
      reverse_o   <= 1'b0;
      clip_en_o   <= 1'b0;
      color_o     <= '0;
      clip_l_o    <= '0;
      clip_r_o    <= '0;
      clip_t_o    <= '0;
      clip_b_o    <= '0;
      x0_o        <= '0;
      y0_o        <= '0;
    end else if (wr_en) begin
      case (addr_i)
        REG_SRC:    src_base_o  <= wdata_i[ADDR_W-1:0];
        REG_DST:    dst_base_o  <= wdata_i[ADDR_W-1:0];
        REG_SPITCH: src_pitch_o <= wdata_i[DIM_W-1:0];
        REG_DPITCH: dst_pitch_o <= wdata_i[DIM_W-1:0];
        REG_WIDTH:  width_o     <= wdata_i[DIM_W-1:0];
        REG_HEIGHT: height_o    <= wdata_i[DIM_W-1:0];
        REG_MODE: begin
          reverse_o <= wdata_i[MODE_REV_BIT];
          clip_en_o <= wdata_i[MODE_CLIP_BIT];
        end
        REG_COLOR:  color_o     <= wdata_i[PIX_W-1:0];
        REG_CLIP_L: clip_l_o    <= wdata_i[DIM_W-1:0];
        REG_CLIP_R: clip_r_o    <= wdata_i[DIM_W-1:0];
        REG_CLIP_T: clip_t_o    <= wdata_i[DIM_W-1:0];
        REG_CLIP_B: clip_b_o    <= wdata_i[DIM_W-1:0];
        REG_X0:     x0_o        <= wdata_i[DIM_W-1:0];
        REG_Y0:     y0_o        <= wdata_i[DIM_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/blit_walker.sv
module blit_walker #(
  parameter int ADDR_W = 24,
  parameter int DIM_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              step_i,
  input  logic              reverse_i,
  input  logic [ADDR_W-1:0] src_base_i,
  input  logic [ADDR_W-1:0] dst_base_i,
  input  logic [DIM_W-1:0]  src_pitch_i,
  input  logic [DIM_W-1:0]  dst_pitch_i,
  input  logic [DIM_W-1:0]  width_i,
  input  logic [DIM_W-1:0]  height_i,
  input  logic [DIM_W-1:0]  x0_i,
  input  logic [DIM_W-1:0]  y0_i,
  output logic [ADDR_W-1:0] src_addr_o,
  output logic [ADDR_W-1:0] dst_addr_o,
  output logic [DIM_W-1:0]  x_o,
  output logic [DIM_W-1:0]  y_o,
  output logic              last_o
);
  logic [ADDR_W-1:0] sp_ext, dp_ext;
  logic [ADDR_W-1:0] src_line, dst_line, src_nline, dst_nline;
  logic [DIM_W-1:0]  col_left, row_left;

  // pitch widened or narrowed to address width
  if (ADDR_W > DIM_W) begin : g_widen
    assign sp_ext = {{(ADDR_W-DIM_W){1'b0}}, src_pitch_i};
    assign dp_ext = {{(ADDR_W-DIM_W){1'b0}}, dst_pitch_i};
  end else begin : g_trunc
    logic unused_pitch_hi;
    assign sp_ext = src_pitch_i[ADDR_W-1:0];
    assign dp_ext = dst_pitch_i[ADDR_W-1:0];
    assign unused_pitch_hi = ^{src_pitch_i, dst_pitch_i};
  end

  assign src_nline = reverse_i ? src_line - sp_ext : src_line + sp_ext;
  assign dst_nline = reverse_i ? dst_line - dp_ext : dst_line + dp_ext;
  assign last_o    = (col_left == '0) && (row_left == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_line   <= '0;
      dst_line   <= '0;
      src_addr_o <= '0;
      dst_addr_o <= '0;
      x_o        <= '0;
      y_o        <= '0;
      col_left   <= '0;
      row_left   <= '0;
    end else if (start_i) begin
      src_line   <= src_base_i;
      dst_line   <= dst_base_i;
      src_addr_o <= src_base_i;
      dst_addr_o <= dst_base_i;
      x_o        <= x0_i;
      y_o        <= y0_i;
      col_left   <= width_i - DIM_W'(1);
      row_left   <= height_i - DIM_W'(1);
    end else if (step_i) begin
      if (col_left != '0) begin
        col_left   <= col_left - DIM_W'(1);
        src_addr_o <= reverse_i ? src_addr_o - ADDR_W'(1) : src_addr_o + ADDR_W'(1);
        dst_addr_o <= reverse_i ? dst_addr_o - ADDR_W'(1) : dst_addr_o + ADDR_W'(1);
        x_o        <= reverse_i ? x_o - DIM_W'(1) : x_o + DIM_W'(1);
      end else if (row_left != '0) begin
        row_left   <= row_left - DIM_W'(1);
        col_left   <= width_i - DIM_W'(1);
        src_line   <= src_nline;
        dst_line   <= dst_nline;
        src_addr_o <= src_nline;
        dst_addr_o <= dst_nline;
        x_o        <= x0_i;
        y_o        <= reverse_i ? y_o - DIM_W'(1) : y_o + DIM_W'(1);
      end
    end
  end
endmodule

// File: rtl/blit_clip.sv
module blit_clip #(
  parameter int DIM_W = 16
) (
  input  logic             en_i,
  input  logic [DIM_W-1:0] x_i,
  input  logic [DIM_W-1:0] y_i,
  input  logic [DIM_W-1:0] left_i,
  input  logic [DIM_W-1:0] right_i,
  input  logic [DIM_W-1:0] top_i,
  input  logic [DIM_W-1:0] bottom_i,
  output logic             visible_o
);
  logic in_x, in_y;
  assign in_x      = (x_i >= left_i) && (x_i <= right_i);
  assign in_y      = (y_i >= top_i) && (y_i <= bottom_i);
  assign visible_o = !en_i || (in_x && in_y);
endmodule

// File: rtl/rect_blit_engine.sv
module rect_blit_engine
  import blit_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DIM_W  = 16,
  parameter int PIX_W  = 8,
  parameter int DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [3:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [3:0]        status_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [PIX_W-1:0]  mem_wdata_o,
  input  logic [PIX_W-1:0]  mem_rdata_i,
  input  logic              mem_ready_i
);
  logic [ADDR_W-1:0] src_base, dst_base, src_addr, dst_addr;
  logic [DIM_W-1:0]  src_pitch, dst_pitch, width, height, x0, y0;
  logic [DIM_W-1:0]  clip_l, clip_r, clip_t, clip_b, cur_x, cur_y;
  logic [PIX_W-1:0]  color, rdata_q;
  logic              reverse, clip_en, start, start_copy, op_copy;
  logic              busy, last_pix, pix_vis, advance;
  state_e            state_q, state_d;

  assign busy = (state_q != ST_IDLE);

  blit_regs #(.ADDR_W(ADDR_W), .DIM_W(DIM_W), .PIX_W(PIX_W), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .busy_i(busy),
    .src_base_o(src_base), .dst_base_o(dst_base),
    .src_pitch_o(src_pitch), .dst_pitch_o(dst_pitch),
    .width_o(width), .height_o(height),
    .reverse_o(reverse), .clip_en_o(clip_en), .color_o(color),
    .clip_l_o(clip_l), .clip_r_o(clip_r), .clip_t_o(clip_t), .clip_b_o(clip_b),
    .x0_o(x0), .y0_o(y0),
    .start_o(start), .copy_o(start_copy)
  );

  blit_walker #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_walker (
    .clk_i, .rst_ni,
    .start_i(start), .step_i(advance), .reverse_i(reverse),
    .src_base_i(src_base), .dst_base_i(dst_base),
    .src_pitch_i(src_pitch), .dst_pitch_i(dst_pitch),
    .width_i(width), .height_i(height), .x0_i(x0), .y0_i(y0),
    .src_addr_o(src_addr), .dst_addr_o(dst_addr),
    .x_o(cur_x), .y_o(cur_y), .last_o(last_pix)
  );

  blit_clip #(.DIM_W(DIM_W)) u_clip (
    .en_i(clip_en), .x_i(cur_x), .y_i(cur_y),
    .left_i(clip_l), .right_i(clip_r), .top_i(clip_t), .bottom_i(clip_b),
    .visible_o(pix_vis)
  );

  // a clipped pixel retires in one cycle without touching memory
  always_comb begin
    state_d = state_q;
    advance = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = start_copy ? ST_READ : ST_WRITE;
      ST_READ: begin
        if (!pix_vis) advance = 1'b1;
        else if (mem_ready_i) state_d = ST_WRITE;
      end
      ST_WRITE: if (!pix_vis || mem_ready_i) advance = 1'b1;
      default:  state_d = ST_IDLE;
    endcase
    if (advance) state_d = last_pix ? ST_IDLE : (op_copy ? ST_READ : ST_WRITE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_copy <= 1'b0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (start) op_copy <= start_copy;
      if (state_q == ST_READ && pix_vis && mem_ready_i) rdata_q <= mem_rdata_i;
    end
  end

  assign mem_req_o   = busy && pix_vis;
  assign mem_we_o    = (state_q == ST_WRITE);
  assign mem_addr_o  = mem_we_o ? dst_addr : src_addr;
  assign mem_wdata_o = op_copy ? rdata_q : color;
  assign status_o    = busy ? {1'b0, !op_copy, op_copy, 1'b1} : 4'd0;
endmodule

// File: rtl/blit_checker.sv
module blit_checker #(
  parameter int ADDR_W = 24,
  parameter int DIM_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [3:0]        reg_addr_i,
  input logic [3:0]        status_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic              mem_ready_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              last_pix,
  input logic              clip_en,
  input logic [DIM_W-1:0]  cur_x,
  input logic [DIM_W-1:0]  cur_y,
  input logic [DIM_W-1:0]  clip_l,
  input logic [DIM_W-1:0]  clip_r,
  input logic [DIM_W-1:0]  clip_t,
  input logic [DIM_W-1:0]  clip_b
);
  assert_start_by_cmd_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o != 4'd0) |-> $past(reg_we_i && reg_addr_i == 4'd15));

  assert_read_then_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o && mem_ready_i) |=> (mem_req_o && mem_we_o));

  assert_clip_inside_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && clip_en) |->
      (cur_x >= clip_l && cur_x <= clip_r && cur_y >= clip_t && cur_y <= clip_b));

  assert_req_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  assert_req_when_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> status_o[0]);

  assert_idle_after_last_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && mem_ready_i && last_pix) |=> (status_o == 4'd0));
endmodule

bind rect_blit_engine blit_checker #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_blit_checker (.*);

// File: tb/tb_rect_blit_engine.sv
`timescale 1ns/1ps
module tb_rect_blit_engine;
  localparam int AW   = 12;
  localparam int DW   = 16;
  localparam int PW   = 8;
  localparam int DTW  = 16;
  localparam int MEMN = 1 << AW;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           reg_we = 1'b0;
  logic [3:0]     reg_addr = '0;
  logic [DTW-1:0] reg_wdata = '0;
  logic [3:0]     status;
  logic           mem_req, mem_we, mem_ready = 1'b0;
  logic [AW-1:0]  mem_addr;
  logic [PW-1:0]  mem_wdata, mem_rdata;

  logic [7:0] tb_mem  [MEMN];
  logic [7:0] mdl_mem [MEMN];
  logic [7:0] snap    [MEMN];

  int n_tests = 0, n_fail = 0;

  // configuration shadow
  int c_src, c_dst, c_sp, c_dp, c_w, c_h, c_x0, c_y0, c_col;
  int c_cl, c_cr, c_ct, c_cb;
  bit c_rev, c_clip;

  bit q_we[$];
  int q_addr[$];
  int q_data[$];

  always #2.5 clk = ~clk;

  assign mem_rdata = tb_mem[mem_addr];

  rect_blit_engine #(.ADDR_W(AW), .DIM_W(DW), .PIX_W(PW), .DATA_W(DTW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .status_o(status),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ready_i(mem_ready)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(int idx, int val);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'(idx); reg_wdata = DTW'(val);
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  // R1 register indices and mode bit positions
  task automatic cfg(int src, int dst, int sp, int dp, int w, int h, bit rev, bit clip,
                     int col, int x0, int y0, int cl, int cr, int ct, int cb);
    c_src = src; c_dst = dst; c_sp = sp; c_dp = dp; c_w = w; c_h = h;
    c_rev = rev; c_clip = clip; c_col = col; c_x0 = x0; c_y0 = y0;
    c_cl = cl; c_cr = cr; c_ct = ct; c_cb = cb;
    wr(0, src); wr(1, dst); wr(2, sp); wr(3, dp); wr(4, w); wr(5, h);
    wr(6, {30'd0, clip, rev}); wr(7, col);
    wr(8, cl); wr(9, cr); wr(10, ct); wr(11, cb); wr(12, x0); wr(13, y0);
  endtask

  function automatic bit build(bit copy);
    int sg = c_rev ? -1 : 1;
    bit vis = 1'b0;
    for (int r = 0; r < c_h; r++) begin
      for (int c = 0; c < c_w; c++) begin
        int da = (c_dst + sg * (r * c_dp + c)) & (MEMN - 1);
        int sa = (c_src + sg * (r * c_sp + c)) & (MEMN - 1);
        int x  = (c_x0 + sg * c) & 16'hFFFF;
        int y  = (c_y0 + sg * r) & 16'hFFFF;
        int v;
        vis = !c_clip || (x >= c_cl && x <= c_cr && y >= c_ct && y <= c_cb);
        if (vis) begin
          if (copy) begin
            q_we.push_back(1'b0); q_addr.push_back(sa); q_data.push_back(0);
            v = mdl_mem[sa];
          end else v = c_col & 8'hFF;
          q_we.push_back(1'b1); q_addr.push_back(da); q_data.push_back(v);
          mdl_mem[da] = 8'(v);
        end
      end
    end
    return vis;
  endfunction

  task automatic run(bit copy, bit stall, bit poke, string req);
    bit tight, pend_zero = 1'b0, first = 1'b1;
    int cyc = 0, bad = 0;
    tight = build(copy);
    wr(15, copy ? 2 : 1);
    @(negedge clk);
    forever begin
      if (pend_zero) begin
        check(status == 4'd0, "R10", "status after last write", status, 0);
        pend_zero = 1'b0;
      end
      if (first) begin
        check(status == (copy ? 4'b0011 : 4'b0101), "R8", "busy status", status,
              copy ? 3 : 5);
        first = 1'b0;
      end else if (status == 4'd0) break;
      mem_ready = stall ? (cyc % 3 != 1) : 1'b1;
      reg_we = 1'b0;
      if (poke && cyc == 2) begin reg_we = 1'b1; reg_addr = 4'd7;  reg_wdata = 16'hEE; end
      if (poke && cyc == 3) begin reg_we = 1'b1; reg_addr = 4'd15; reg_wdata = 16'd1;  end
      if (mem_req) begin
        if (q_we.size() == 0) begin
          check(1'b0, req, "unexpected request addr", mem_addr, -1);
        end else begin
          bit ok = (mem_we == q_we[0]) && (mem_addr == AW'(q_addr[0]))
                   && (!mem_we || mem_wdata == 8'(q_data[0]));
          check(ok, req, mem_we ? "write addr/data" : "read addr",
                mem_we ? (int'(mem_addr) * 256 + mem_wdata) : int'(mem_addr),
                q_we[0] ? (q_addr[0] * 256 + q_data[0]) : q_addr[0]);
          if (mem_ready) begin
            if (mem_we) tb_mem[mem_addr] = mem_wdata;
            void'(q_we.pop_front()); void'(q_addr.pop_front()); void'(q_data.pop_front());
            if (q_we.size() == 0 && tight) pend_zero = 1'b1;
          end
        end
      end
      cyc++;
      if (cyc > 5000) begin
        check(1'b0, req, "operation did not finish", cyc, 5000);
        break;
      end
      @(negedge clk);
    end
    mem_ready = 1'b0; reg_we = 1'b0;
    check(q_we.size() == 0, req, "missing transactions", q_we.size(), 0);
    for (int i = 0; i < MEMN; i++) if (tb_mem[i] !== mdl_mem[i]) bad++;
    check(bad == 0, req, "frame buffer mismatches", bad, 0);
    q_we.delete(); q_addr.delete(); q_data.delete();
  endtask

  task automatic expect_idle(string req, string what);
    int seen = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (status != 4'd0 || mem_req) seen++;
    end
    check(seen == 0, req, what, seen, 0);
  endtask

  initial begin
    #(200000 * 5);
    check(1'b0, "WDOG", "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < MEMN; i++) begin
      tb_mem[i] = 8'((i * 7 + 3) & 8'hFF);
      mdl_mem[i] = tb_mem[i];
    end
    repeat (3) @(negedge clk);
    check(status == 4'd0, "R12", "status after reset", status, 0);
    check(mem_req == 1'b0, "R12", "request after reset", mem_req, 0);
    rst_n = 1'b1;
    // R12: registers zero, so a command with zero size stays idle
    wr(15, 1);
    expect_idle("R12", "command on reset registers");

    // R3 forward fill
    cfg(0, 100, 0, 64, 5, 3, 0, 0, 8'h5A, 0, 0, 0, 0, 0, 0);
    run(1'b0, 1'b0, 1'b0, "R3");

    // R7 stalled fill; R9 colour and command writes while busy
    cfg(0, 600, 0, 40, 4, 4, 0, 0, 8'h33, 0, 0, 0, 0, 0, 0);
    run(1'b0, 1'b1, 1'b1, "R9");
    expect_idle("R9", "command written while busy started");

    // R4 copy with distinct pitches, stalled memory
    cfg(1000, 2000, 50, 70, 6, 4, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    run(1'b1, 1'b1, 1'b0, "R4");

    // R5 overlapping reverse copy: region moves one line down and one pixel right
    for (int i = 0; i < MEMN; i++) snap[i] = tb_mem[i];
    cfg(300 + 4 * 64 + 7, 365 + 4 * 64 + 7, 64, 64, 8, 5, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    run(1'b1, 1'b0, 1'b0, "R5");
    begin
      int bad = 0;
      for (int r = 0; r < 5; r++)
        for (int c = 0; c < 8; c++)
          if (tb_mem[365 + r * 64 + c] !== snap[300 + r * 64 + c]) bad++;
      check(bad == 0, "R5", "overlap copy corrupted pixels", bad, 0);
    end

    // R6 clip cutting first rows and last column, last pixel clipped (R1 mode bit 1)
    cfg(0, 1500, 0, 32, 6, 5, 0, 1, 8'hC3, 10, 20, 12, 14, 21, 23);
    run(1'b0, 1'b0, 1'b0, "R6");

    // R6 with R5: reverse fill, bounds equal to coordinates
    cfg(0, 2500 + 3 * 32 + 4, 0, 32, 5, 4, 1, 1, 8'h9E, 30, 40, 26, 30, 37, 40);
    run(1'b0, 1'b1, 1'b0, "R6");

    // R6 clipped copy
    cfg(3000, 3400, 20, 24, 4, 3, 0, 1, 0, 5, 5, 6, 7, 5, 6);
    run(1'b1, 1'b1, 1'b0, "R6");

    // R11 wrap past top address
    cfg(0, MEMN - 2, 0, 16, 4, 2, 0, 0, 8'h77, 0, 0, 0, 0, 0, 0);
    run(1'b0, 1'b0, 1'b0, "R11");

    // R2 unknown command code
    wr(15, 3);
    expect_idle("R2", "code 3 started engine");
    // R2 zero height
    cfg(0, 100, 0, 64, 5, 0, 0, 0, 8'h11, 0, 0, 0, 0, 0, 0);
    wr(15, 1);
    expect_idle("R2", "zero height started engine");
    wr(15, 2);
    expect_idle("R2", "zero height copy started engine");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule